// File: doc/BRIEF.md
# Multi-Mode Timer/Event Counter

An 8-bit up-counter with a preload register, a programmable prescaler on the system clock, and three ways of advancing. It can count active edges of an external input. It can count ticks of the prescaled clock to time intervals. It can also measure one pulse width by counting prescaled ticks between an active edge and the opposite edge. Software programs the block through a control register, writes the preload value and reads back the live count.

When the count rolls over from all-ones, the counter reloads from the preload register. At the same moment it raises a one-clock interrupt request and toggles a buzzer flip-flop, so the buzzer line runs at half the overflow rate. The external input must already be synchronous to the clock. Pin multiplexing, wake-up and interrupt routing are left to surrounding logic.

Top module: `tmr_multimode`

## Requirements
- R1: Control field [2:0] selects a count tick of one clock in every 2^(code+1) system clocks: code 0 gives /2 and code 7 gives /256.
- R2: Control bit [5] is reserved and always reads back 0. The other control bits read back as written. Reset clears the control register, count, preload, interrupt request and buzzer output.
- R3: In event mode (control [7:6] = 01), each active edge of `ev_in` adds one to the count. Control bit [3] = 0 makes rising edges active; [3] = 1 makes falling edges active.
- R4: In timer mode (control [7:6] = 10), each prescaled tick adds one to the count. In mode 00 the counter never advances, even with the run bit set.
- R5: An increment from 0xFF loads the preload value and produces a one-clock request on `irq`. The request is visible only while `irq_en` is 1.
- R6: `bz` toggles on every overflow, whether or not the interrupt is enabled.
- R7: In pulse width mode (control [7:6] = 11, run bit set), an active edge of `ev_in` starts counting prescaled ticks. The next opposite edge stops counting and clears the run bit. Later pulses are ignored until software sets the run bit again.
- R8: Control bit [4] is the run bit. With the run bit at 0 the count holds. In event and timer modes hardware never clears the run bit.
- R9: A preload write while the run bit is 0 also loads the count. While the run bit is 1 it changes only the preload register, and the new value is used at the next overflow.
- R10: While `cnt_rd` is high, the count does not advance. Ticks or edges that arrive during the read are dropped, not made up afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Write strobe for the control register |
| ctrl_wdata | input | 8 | Control register write data |
| load_wr | input | 1 | Write strobe for the preload register |
| load_wdata | input | W | Preload write data |
| cnt_rd | input | 1 | Count read in progress; blocks counting |
| ev_in | input | 1 | Synchronized external event/pulse input |
| irq_en | input | 1 | Interrupt enable |
| ctrl_o | output | 8 | Control register readback |
| cnt_o | output | W | Live count value |
| irq | output | 1 | One-clock overflow interrupt request |
| bz | output | 1 | Buzzer output, toggles on each overflow |

## Verification
The assertions assume that `ev_in` is already synchronous and does not toggle on two consecutive clocks. This keeps overflows at least two cycles apart, which the single-cycle request property depends on. The assertions also assume that a preload write never lands in the same cycle as a roll-over. The stimulus holds every level of `ev_in` for at least one full clock and issues preload writes only while no increment is possible. Timed windows are sized to whole prescaler periods, so the expected counts do not depend on the prescaler phase.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_PULSE = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e  mode;
        logic       rsvd;
        logic       run;
        logic       fall_sel;
        logic [2:0] psc;
    } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int STAGES = 8,
    localparam int SELW  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] sel,
    output logic            tick
);
    logic [STAGES-1:0] div_d, div_q;
    logic [STAGES-1:0] tap;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_tap
            assign tap[i] = &div_q[i:0];
        end
    endgenerate

    always_comb begin
        div_d = div_q + 1'b1;
        tick  = tap[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // R1: the shortest divide is two, so a tick is never followed by another
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tmr_edge.sv
module tmr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    input  logic fall_sel,
    output logic act,
    output logic inact
);
    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = sig;
        rise   = sig & ~prev_q;
        fall   = ~sig & prev_q;
        act    = fall_sel ? fall : rise;
        inact  = fall_sel ? rise : fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    // R3: an active edge cannot repeat on the next clock
    p_act_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> !act);
endmodule

// File: rtl/tmr_multimode.sv
module tmr_multimode
    import tmr_pkg::*;
#(
    parameter int W      = 8,
    parameter int STAGES = 8,
    localparam int SELW  = (STAGES > 1) ? $clog2(STAGES) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctrl_wr,
    input  logic [7:0]   ctrl_wdata,
    input  logic         load_wr,
    input  logic [W-1:0] load_wdata,
    input  logic         cnt_rd,
    input  logic         ev_in,
    input  logic         irq_en,
    output logic [7:0]   ctrl_o,
    output logic [W-1:0] cnt_o,
    output logic         irq,
    output logic         bz
);
    typedef struct packed {
        tmr_ctrl_t    ctrl;
        logic [W-1:0] pre;
        logic [W-1:0] cnt;
        logic         meas;
        logic         irq;
        logic         bz;
    } state_t;

    state_t    st_d, st_q;
    logic      tick, act, inact;
    logic      step, inc;
    tmr_ctrl_t wr_ctrl;

    tmr_prescale #(.STAGES(STAGES)) u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .sel  (st_q.ctrl.psc[SELW-1:0]),
        .tick (tick)
    );

    tmr_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig     (ev_in),
        .fall_sel(st_q.ctrl.fall_sel),
        .act     (act),
        .inact   (inact)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        wr_ctrl  = tmr_ctrl_t'(ctrl_wdata);

        unique case (st_q.ctrl.mode)
            MODE_EVENT: step = act;
            MODE_TIMER: step = tick;
            MODE_PULSE: step = st_q.meas & tick;
            default:    step = 1'b0;
        endcase
        inc = st_q.ctrl.run & step & ~cnt_rd;

        if (inc) begin
            if (st_q.cnt == '1) begin
                st_d.cnt = st_q.pre;
                st_d.irq = 1'b1;
                st_d.bz  = ~st_q.bz;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (st_q.ctrl.mode == MODE_PULSE && st_q.ctrl.run) begin
            if (!st_q.meas && act) begin
                st_d.meas = 1'b1;
            end else if (st_q.meas && inact) begin
                st_d.meas     = 1'b0;
                st_d.ctrl.run = 1'b0;
            end
        end

        if (load_wr) begin
            st_d.pre = load_wdata;
            if (!st_q.ctrl.run) st_d.cnt = load_wdata;
        end

        if (ctrl_wr) begin
            st_d.ctrl      = wr_ctrl;
            st_d.ctrl.rsvd = 1'b0;
            if (!wr_ctrl.run || wr_ctrl.mode != MODE_PULSE) st_d.meas = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_o = st_q.ctrl;
    assign cnt_o  = st_q.cnt;
    assign irq    = st_q.irq & irq_en;
    assign bz     = st_q.bz;

    // R5: the request lasts a single clock
    p_irq_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |=> !st_q.irq);

    // R5: a roll-over lands on the preload value
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && st_q.cnt == '1 && !load_wr) |=> (st_q.cnt == $past(st_q.pre)));

    // R6: the buzzer only changes together with an overflow
    p_bz_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.bz) |-> st_q.irq);

    // R8: a stopped counter holds unless software loads it
    p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.ctrl.run && !load_wr) |=> $stable(st_q.cnt));

    // R10: a read in progress freezes the count
    p_read_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rd && !load_wr) |=> $stable(st_q.cnt));

    // R8: outside pulse mode the run bit falls only on a control write
    p_run_sw_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.run && st_q.ctrl.mode != MODE_PULSE && !ctrl_wr) |=> st_q.ctrl.run);
endmodule

// File: tb/tmr_multimode_tb.sv
`timescale 1ns/1ps
module tmr_multimode_tb;
    localparam int W = 8;
    localparam logic [2:0] OP_CTL  = 3'd0;
    localparam logic [2:0] OP_LOAD = 3'd1;
    localparam logic [2:0] OP_EDGE = 3'd2;
    localparam logic [2:0] OP_CCNT = 3'd3;
    localparam logic [2:0] OP_CCTL = 3'd4;
    localparam int NV = 18;
    // {requirement number, operation, data}
    localparam logic [14:0] VEC [NV] = '{
        {4'd2, OP_CTL,  8'h20}, {4'd2, OP_CCTL, 8'h00},
        {4'd9, OP_LOAD, 8'h05}, {4'd9, OP_CCNT, 8'h05},
        {4'd3, OP_CTL,  8'h50}, {4'd3, OP_EDGE, 8'h00},
        {4'd3, OP_EDGE, 8'h00}, {4'd3, OP_CCNT, 8'h07},
        {4'd8, OP_CCTL, 8'h50},
        {4'd4, OP_CTL,  8'h10}, {4'd4, OP_EDGE, 8'h00},
        {4'd4, OP_CCNT, 8'h07},
        {4'd8, OP_CTL,  8'h40}, {4'd8, OP_EDGE, 8'h00},
        {4'd8, OP_CCNT, 8'h07},
        {4'd2, OP_CTL,  8'hA7}, {4'd2, OP_CCTL, 8'h87},
        {4'd2, OP_CTL,  8'h00}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ctrl_wr = 1'b0;
    logic [7:0]   ctrl_wdata = '0;
    logic         load_wr = 1'b0;
    logic [W-1:0] load_wdata = '0;
    logic         cnt_rd = 1'b0;
    logic         ev_in = 1'b0;
    logic         irq_en = 1'b0;
    logic [7:0]   ctrl_o;
    logic [W-1:0] cnt_o;
    logic         irq, bz;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tmr_multimode #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .load_wr(load_wr), .load_wdata(load_wdata), .cnt_rd(cnt_rd),
        .ev_in(ev_in), .irq_en(irq_en), .ctrl_o(ctrl_o), .cnt_o(cnt_o),
        .irq(irq), .bz(bz)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctrl_wdata = v; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_load(input logic [7:0] v);
        load_wdata = v; load_wr = 1'b1;
        @(negedge clk);
        load_wr = 1'b0;
    endtask

    task automatic pulse(output logic irq_seen, output logic irq_after);
        ev_in = 1'b1;
        @(negedge clk);
        irq_seen = irq;
        ev_in = 1'b0;
        @(negedge clk);
        irq_after = irq;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic s, a;
        logic [7:0] v0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2, R5, R6)
        chk("R2 reset ctrl", ctrl_o, 8'h00);
        chk("R2 reset count", cnt_o, 8'h00);
        chk("R5 reset irq", irq, 0);
        chk("R6 reset bz", bz, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d table %0d", VEC[i][14:11], i);
            unique case (VEC[i][10:8])
                OP_CTL:  wr_ctl(VEC[i][7:0]);
                OP_LOAD: wr_load(VEC[i][7:0]);
                OP_EDGE: pulse(s, a);
                OP_CCNT: chk(tag, cnt_o, VEC[i][7:0]);
                default: chk(tag, ctrl_o, VEC[i][7:0]);
            endcase
        end

        // R3: falling-edge selection
        wr_load(8'h00);
        wr_ctl(8'h58);
        ev_in = 1'b1; @(negedge clk);
        chk("R3 rising ignored with fall select", cnt_o, 0);
        ev_in = 1'b0; @(negedge clk);
        chk("R3 falling counted", cnt_o, 1);

        // R1/R4: timer mode at /2, /4, /256
        wr_ctl(8'h00); wr_load(8'h00);
        wr_ctl(8'h90); repeat (19) @(negedge clk); wr_ctl(8'h00);
        chk("R1 R4 divide by 2", cnt_o, 10);
        wr_load(8'h00);
        wr_ctl(8'h91); repeat (39) @(negedge clk); wr_ctl(8'h00);
        chk("R1 R4 divide by 4", cnt_o, 10);
        wr_load(8'h00);
        wr_ctl(8'h97); repeat (511) @(negedge clk); wr_ctl(8'h00);
        chk("R1 R4 divide by 256", cnt_o, 2);

        // R10: read gating drops ticks
        wr_load(8'h00);
        wr_ctl(8'h90); repeat (5) @(negedge clk);
        cnt_rd = 1'b1; v0 = cnt_o;
        repeat (10) @(negedge clk);
        chk("R10 frozen during read", cnt_o, v0);
        cnt_rd = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 lost ticks not made up", cnt_o, (v0 + 5) & 8'hFF);
        wr_ctl(8'h00);

        // R5/R6: overflow, request, buzzer
        wr_load(8'hFD);
        irq_en = 1'b1;
        wr_ctl(8'h50);
        pulse(s, a); chk("R5 no irq at FE", s, 0);
        pulse(s, a); chk("R5 no irq at FF", s, 0);
        pulse(s, a); chk("R5 irq on overflow", s, 1);
        chk("R5 irq lasts one clock", a, 0);
        chk("R5 reload from preload", cnt_o, 8'hFD);
        chk("R6 bz toggled", bz, 1);
        irq_en = 1'b0;
        pulse(s, a); pulse(s, a); pulse(s, a);
        chk("R5 masked irq", s, 0);
        chk("R6 bz toggles when masked", bz, 0);

        // R9: preload write while running
        wr_load(8'h30);
        chk("R9 running count untouched", cnt_o, 8'hFD);
        pulse(s, a); pulse(s, a); pulse(s, a);
        chk("R9 new preload at overflow", cnt_o, 8'h30);

        // R7: pulse width measurement
        wr_ctl(8'h00); wr_load(8'h00);
        wr_ctl(8'hD0);
        ev_in = 1'b1; repeat (20) @(negedge clk);
        ev_in = 1'b0; @(negedge clk);
        chk("R7 measured width", cnt_o, 10);
        chk("R7 run bit self-cleared", ctrl_o, 8'hC0);
        ev_in = 1'b1; repeat (6) @(negedge clk);
        ev_in = 1'b0; @(negedge clk);
        chk("R7 later pulse ignored", cnt_o, 10);
        wr_ctl(8'hD0); repeat (4) @(negedge clk);
        chk("R7 armed waits for edge", cnt_o, 10);
        ev_in = 1'b1; repeat (8) @(negedge clk);
        ev_in = 1'b0; @(negedge clk);
        chk("R7 second measurement", cnt_o, 14);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule